// File: doc/BRIEF.md
# Interleaved SEC-DED Protected Word Memory

This block wraps a small single-port memory and protects every 8-bit data word against upsets in the stored cells. On a write, the word is split into a low and a high nibble. Each nibble goes through its own Hamming(7,4) encoder, which adds an overall parity bit, so each nibble becomes an 8-bit codeword. The two codewords are merged bit by bit into one 16-bit stored word. Because of this merge, any two physically neighbouring cells always belong to different codewords. A burst of two adjacent flipped cells therefore shows up as one error in each codeword, and both errors are corrected.

On a read, both codewords are decoded in parallel. A single error in either codeword is repaired. A double error inside one codeword is reported as uncorrectable. The result and two status flags are registered, with one cycle of latency. A test port can XOR an error mask into any stored word, so that upsets can be produced on purpose. The code protects only the stored cells. A write that lands at the wrong address cannot be seen by this block.

A small controller picks one operation each cycle from the inputs. The operations form the states of the controller, and the state register holds the operation of the previous cycle:
- `OP_WRITE` is chosen when `ce`=1 and `we`=1.
- `OP_READ` is chosen when `ce`=1 and `we`=0.
- `OP_INJECT` is chosen when `ce`=0 and `inj_en`=1.
- `OP_IDLE` is chosen in every other case.

Any state can move to any other on the next cycle, because the transition depends only on the inputs of that cycle. Only `OP_READ` loads the output registers.

Top module: `ilv_secded_mem`

## Requirements
- R1: After reset, `rd_data`, `corrected` and `uncorrectable` are 0. Every stored word is cleared to the all-zero codeword, so a read of any address returns 0 with both flags low.
- R2: A read (`ce`=1, `we`=0) updates `rd_data`, `corrected` and `uncorrectable` at the clock edge that ends the read cycle. Data written earlier and not disturbed afterwards reads back unchanged, with both flags low.
- R3: In any cycle that is not a read, the three outputs keep their values. This includes writes, injections and idle cycles.
- R4: Injection applies only when `ce`=0. In that case `inj_en`=1 replaces the stored word at `inj_addr` with that word XOR `inj_mask`. When `ce`=1, the injection request is ignored.
- R5: An error in any single one of the 16 stored bits is corrected. The read returns the original data with `corrected`=1 and `uncorrectable`=0.
- R6: Flipping stored bits 2k and 2k+1 together, for any k from 0 to 7, is corrected. The read returns the original data with `corrected`=1 and `uncorrectable`=0.
- R7: Two errors inside one codeword, with the other codeword clean, give `uncorrectable`=1 and `corrected`=0.
- R8: A single error in one codeword together with a double error in the other gives `corrected`=1 and `uncorrectable`=1.
- R9: Stored bit 2k holds bit k of the low-nibble codeword, and stored bit 2k+1 holds bit k of the high-nibble codeword. Within a codeword:
  - bits 2, 4, 5 and 6 carry data nibble bits 0 to 3;
  - bits 0, 1 and 3 are the Hamming checks for positions 1, 2 and 4;
  - bit 7 makes the parity of the whole codeword even.
- R10: A codeword with a non-zero syndrome and good overall parity is left uncorrected. Its output nibble is taken as-is from codeword bits 2, 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip enable for the normal access |
| we | input | 1 | Write select when `ce` is high |
| addr | input | ADDR_W | Word address for read or write |
| wr_data | input | 8 | Data to store |
| rd_data | output | 8 | Registered read data |
| corrected | output | 1 | The last read fixed a single error in at least one codeword |
| uncorrectable | output | 1 | The last read found a double error in at least one codeword |
| inj_en | input | 1 | Test request to flip stored bits |
| inj_addr | input | ADDR_W | Word to disturb |
| inj_mask | input | 16 | Stored bits to invert |

## Verification
The bench builds the block with the default ADDR_W of 4, which gives 16 words. With this size, random traffic revisits every address often, so injected errors build up and are read back in many combinations. Directed sweeps cover every single stored-bit position, including the two parity bits, and all eight adjacent pairs. Hand-picked masks produce a same-codeword double error, a raw-data uncorrectable case and a mixed single/double word. The bench also checks an injection request made during an access, which must be ignored.

// File: rtl/ilv_secded_pkg.sv
package ilv_secded_pkg;
    localparam int HALF_W = 4;
    localparam int LANES  = 2;
    localparam int CW_W   = HALF_W + 4;
    localparam int DATA_W = HALF_W * LANES;
    localparam int WORD_W = CW_W * LANES;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_WRITE,
        OP_READ,
        OP_INJECT
    } op_e;
endpackage

// File: rtl/ilv_hm_enc.sv
module ilv_hm_enc
    import ilv_secded_pkg::*;
(
    input  logic [HALF_W-1:0] nib,
    output logic [CW_W-1:0]   cw
);
    logic [CW_W-2:0] h;

    always_comb begin
        h[2] = nib[0];
        h[4] = nib[1];
        h[5] = nib[2];
        h[6] = nib[3];
        h[0] = nib[0] ^ nib[1] ^ nib[3];
        h[1] = nib[0] ^ nib[2] ^ nib[3];
        h[3] = nib[1] ^ nib[2] ^ nib[3];
        cw   = {^h, h};
    end
endmodule

// File: rtl/ilv_hm_dec.sv
module ilv_hm_dec
    import ilv_secded_pkg::*;
(
    input  logic [CW_W-1:0]   cw,
    output logic [HALF_W-1:0] nib,
    output logic              fix_one,
    output logic              bad_two
);
    logic [2:0]      syn;
    logic [2:0]      syn_after;
    logic            par_bad;
    logic [CW_W-1:0] fixed;

    always_comb begin
        syn[0]  = cw[0] ^ cw[2] ^ cw[4] ^ cw[6];
        syn[1]  = cw[1] ^ cw[2] ^ cw[5] ^ cw[6];
        syn[2]  = cw[3] ^ cw[4] ^ cw[5] ^ cw[6];
        par_bad = ^cw;
        fixed   = cw;
        if (par_bad && (syn != 3'd0)) begin
            fixed[syn - 3'd1] = ~cw[syn - 3'd1];
        end
        nib     = {fixed[6], fixed[5], fixed[4], fixed[2]};
        fix_one = par_bad;
        bad_two = !par_bad && (syn != 3'd0);
    end

    // syndrome recomputed on the repaired word, used by the check below
    always_comb begin
        syn_after[0] = fixed[0] ^ fixed[2] ^ fixed[4] ^ fixed[6];
        syn_after[1] = fixed[1] ^ fixed[2] ^ fixed[5] ^ fixed[6];
        syn_after[2] = fixed[3] ^ fixed[4] ^ fixed[5] ^ fixed[6];
        if (fix_one) begin
            AST_FIX_CLEARS_SYNDROME: assert (syn_after == 3'd0) else $error("repair left syndrome"); // R5
        end
    end
endmodule

// File: rtl/ilv_word_store.sv
module ilv_word_store
    import ilv_secded_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              flip_en,
    input  logic [ADDR_W-1:0] flip_addr,
    input  logic [WORD_W-1:0] flip_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end else if (flip_en) begin
            mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
        end
    end

    assign rd_word = mem[rd_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_word)); // R2

    AST_FLIP_XORS: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_en && !wr_en) |=> mem[$past(flip_addr)] == ($past(mem[flip_addr]) ^ $past(flip_mask))); // R4

    AST_ONE_PORT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && flip_en)); // R4
endmodule

// File: rtl/ilv_secded_mem.sv
module ilv_secded_mem
    import ilv_secded_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              corrected,
    output logic              uncorrectable,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [WORD_W-1:0] inj_mask
);
    op_e               op_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CW_W-1:0]   enc_cw [LANES];
    logic [CW_W-1:0]   dec_cw [LANES];
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    logic [DATA_W-1:0] dec_data;
    logic [LANES-1:0]  lane_fix;
    logic [LANES-1:0]  lane_bad;

    // operation chosen this cycle
    always_comb begin
        op_d = OP_IDLE;
        if (ce) begin
            op_d = we ? OP_WRITE : OP_READ;
        end else if (inj_en) begin
            op_d = OP_INJECT;
        end
    end

    // state register: operation of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
        end else begin
            op_q   <= op_d;
            addr_q <= addr;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data       <= '0;
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
        end else begin
            unique case (op_d)
                OP_READ: begin
                    rd_data       <= dec_data;
                    corrected     <= |lane_fix;
                    uncorrectable <= |lane_bad;
                end
                OP_IDLE, OP_WRITE, OP_INJECT: begin
                end
            endcase
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ilv_hm_enc u_enc (
            .nib (wr_data[l*HALF_W +: HALF_W]),
            .cw  (enc_cw[l])
        );
        ilv_hm_dec u_dec (
            .cw      (dec_cw[l]),
            .nib     (dec_data[l*HALF_W +: HALF_W]),
            .fix_one (lane_fix[l]),
            .bad_two (lane_bad[l])
        );
        for (genvar k = 0; k < CW_W; k++) begin : g_bit
            assign wr_word[k*LANES + l] = enc_cw[l][k];
            assign dec_cw[l][k]         = rd_word[k*LANES + l];
        end
    end

    ilv_word_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (op_d == OP_WRITE),
        .wr_addr   (addr),
        .wr_word   (wr_word),
        .flip_en   (op_d == OP_INJECT),
        .flip_addr (inj_addr),
        .flip_mask (inj_mask),
        .rd_addr   (addr),
        .rd_word   (rd_word)
    );

    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_d != OP_READ) |=> ($stable(rd_data) && $stable(corrected) && $stable(uncorrectable))); // R3

    AST_WRITE_READ_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE && op_d == OP_READ && addr == addr_q)
        |=> (rd_data == $past(wr_data, 2) && !corrected && !uncorrectable)); // R2
endmodule

// File: tb/ilv_secded_mem_test.sv
`timescale 1ns/1ps
module ilv_secded_mem_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce, we, inj_en;
    logic [3:0]  addr, inj_addr;
    logic [7:0]  wr_data;
    logic [15:0] inj_mask;
    logic [7:0]  rd_data;
    logic        corrected, uncorrectable;

    always #2.5 clk = ~clk;

    ilv_secded_mem #(.ADDR_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .corrected(corrected),
        .uncorrectable(uncorrectable), .inj_en(inj_en),
        .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] mdl [16];
    logic [7:0]  exp_d;
    logic        exp_c, exp_u;

    // R9 layout: data at positions 3,5,6,7; checks at 1,2,4; bit 7 overall parity
    function automatic logic [7:0] ref_enc(input logic [3:0] n);
        logic [7:0] c = '0;
        int di = 0;
        for (int p = 1; p <= 7; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p-1] = n[di];
                di++;
            end
        end
        for (int b = 0; b < 3; b++) begin
            logic x = 1'b0;
            for (int p = 1; p <= 7; p++) begin
                if (((p >> b) & 1) == 1 && (p & (p - 1)) != 0) x ^= c[p-1];
            end
            c[(1 << b) - 1] = x;
        end
        c[7] = ^c[6:0];
        return c;
    endfunction

    function automatic logic [15:0] ref_word(input logic [7:0] d);
        logic [7:0] c0 = ref_enc(d[3:0]);
        logic [7:0] c1 = ref_enc(d[7:4]);
        logic [15:0] w;
        for (int k = 0; k < 8; k++) begin
            w[2*k]   = c0[k];
            w[2*k+1] = c1[k];
        end
        return w;
    endfunction

    task automatic ref_read(input logic [15:0] w, output logic [7:0] d,
                            output logic c, output logic u);
        c = 1'b0;
        u = 1'b0;
        for (int l = 0; l < 2; l++) begin
            logic [7:0] cw;
            int syn = 0;
            for (int k = 0; k < 8; k++) cw[k] = w[2*k + l];
            for (int p = 1; p <= 7; p++) if (cw[p-1]) syn ^= p;
            if (^cw) begin
                c = 1'b1;
                if (syn != 0) cw[syn-1] = ~cw[syn-1];
            end else if (syn != 0) begin
                u = 1'b1;
            end
            d[4*l +: 4] = {cw[6], cw[5], cw[4], cw[2]};
        end
    endtask

    task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got data=%h corr=%b unc=%b, expected data=%h corr=%b unc=%b",
                     tag, got[9:2], got[1], got[0], expv[9:2], expv[1], expv[0]);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic c, input logic w, input logic [3:0] a,
                        input logic [7:0] d, input logic ie, input logic [3:0] ia,
                        input logic [15:0] m, input string tag);
        ce = c; we = w; addr = a; wr_data = d;
        inj_en = ie; inj_addr = ia; inj_mask = m;
        @(posedge clk);
        #1;
        if (c && w)       mdl[a] = ref_word(d);
        else if (c)       ref_read(mdl[a], exp_d, exp_c, exp_u);
        else if (ie)      mdl[ia] = mdl[ia] ^ m;
        @(negedge clk);
        chk(tag, {rd_data, corrected, uncorrectable}, {exp_d, exp_c, exp_u});
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(1'b1, 1'b0, a, 8'h00, 1'b0, 4'h0, 16'h0, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b1, a, d, 1'b0, 4'h0, 16'h0, tag);
    endtask

    task automatic inj(input logic [3:0] a, input logic [15:0] m, input string tag);
        step(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, a, m, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; ce = 0; we = 0; addr = 0; wr_data = 0;
        inj_en = 0; inj_addr = 0; inj_mask = 0;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        exp_d = 0; exp_c = 0; exp_u = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {rd_data, corrected, uncorrectable}, 10'h0);
        rd(4'd5, "R1 cleared word");
        rd(4'd15, "R1 cleared word");

        wr(4'd3, 8'hA5, "R3 write holds outputs");
        rd(4'd3, "R2 readback");
        wr(4'd9, 8'h3C, "R3 write holds outputs");
        rd(4'd9, "R2 readback");

        for (int j = 0; j < 16; j++) begin
            inj(4'd3, 16'(1) << j, "R4 inject holds outputs");
            rd(4'd3, "R5 single bit");
            inj(4'd3, 16'(1) << j, "R4 inject restore");
        end
        rd(4'd3, "R4 restored");

        for (int k = 0; k < 8; k++) begin
            inj(4'd9, 16'(3) << (2 * k), "R4 inject pair");
            rd(4'd9, "R6 adjacent pair");
            inj(4'd9, 16'(3) << (2 * k), "R4 inject restore");
        end

        inj(4'd3, 16'h0005, "R4 inject");
        rd(4'd3, "R7 R9 same codeword double");
        inj(4'd3, 16'h0005, "R4 inject restore");

        inj(4'd3, 16'h0014, "R4 inject");
        rd(4'd3, "R10 raw data on uncorrectable");
        inj(4'd3, 16'h0014, "R4 inject restore");

        inj(4'd3, 16'h0007, "R4 inject");
        rd(4'd3, "R8 mixed single and double");
        inj(4'd3, 16'h0007, "R4 inject restore");

        step(1'b1, 1'b0, 4'd3, 8'h00, 1'b1, 4'd3, 16'h0001, "R4 inject during read");
        rd(4'd3, "R4 ignored during access");
        step(1'b1, 1'b1, 4'd7, 8'h5A, 1'b1, 4'd7, 16'h0003, "R4 inject during write");
        rd(4'd7, "R4 ignored during write");

        for (int n = 0; n < 3000; n++) begin
            int op = $urandom % 8;
            logic [3:0] a = 4'($urandom);
            if (op < 3) begin
                wr(a, 8'($urandom), "random R2");
            end else if (op < 6) begin
                rd(a, "random R5");
            end else if (op == 6) begin
                int sel = $urandom % 4;
                logic [15:0] m = '0;
                if (sel == 1) m = 16'(1) << ($urandom % 16);
                else if (sel == 2) m = 16'(3) << (2 * ($urandom % 8));
                else if (sel == 3) m = (16'(1) << ($urandom % 16)) | (16'(1) << ($urandom % 16));
                inj(a, m, "random R4");
            end else begin
                step(1'b0, 1'b0, a, 8'h00, 1'b0, a, 16'hFFFF, "random R3 idle");
            end
        end

        finish_run();
    end
endmodule